// File: doc/BRIEF.md
# Clock-Synchronous Serial I/O Unit

This block is a byte-wide serial transceiver in which transmit and receive share a single shift clock. A CPU reaches it through a small register bus. Address 0 holds an 8-bit control register, and address 1 holds the 8-bit shift/data register. The shift clock can come from an internal prescaler that divides the system clock. It can also come from an external clock pin, which passes through a two-flop synchronizer with edge detection.

In internal-clock mode, a data write starts an eight-bit exchange at once. In external-clock mode, a data write only arms the unit. An active-low ready output then tells the external master that it may begin clocking. A write made while the external clock is low is refused and flagged. Received bits are sampled on the rising edge of the shift clock. Transmitted bits change on the falling edge, and the clock idles high. When the eighth bit has been received, the unit raises a one-cycle interrupt request. The block also exports the pin-function enables that the control register selects.

Top module: `csio_unit`

## Requirements
- R1: Control bits 2:0 select the internal shift clock period in system clocks: 000=8, 001=16, 010=32, 011=64, 110=128, 111=256. A started internal transfer raises its interrupt exactly 8×period cycles after the data write.
- R2: Control codes 100 and 101 are reserved. With either code in internal mode, a data write loads the data register but starts no transfer: the shift clock stays high and no interrupt occurs.
- R3: The control register drives four outputs. Bit 3 drives `pin_sel`, bit 4 drives `od_en` and bit 7 drives `rdy_oe`. `sclk_oe` equals bit 3 AND bit 6.
- R4: Control bit 5 selects the bit order: 0 sends and receives LSB first, 1 sends and receives MSB first. After a transfer, the data register holds the received byte in its natural order.
- R5: `sin` is sampled on each rising shift-clock edge. `sout` changes only on falling shift-clock edges. The internal shift clock idles high, and `sout` resets to 1.
- R6: With control bit 6 = 1 (internal clock), a data write resets the bit count and starts an eight-bit transfer immediately. A write during a transfer restarts it.
- R7: With control bit 6 = 0 (external clock), a data write made while the synchronized `sclk_in` is high arms the unit. Shifting then follows the edges of `sclk_in`.
- R8: External `sclk_in` edges that arrive while the unit is not armed change neither the data register nor the interrupt.
- R9: An external-mode data write made while the synchronized `sclk_in` is low sets `err_flag` and does not arm the unit. The next external-mode write made with the clock high clears `err_flag`.
- R10: `rdy_n` is 0 from an external-mode arm until the first synchronized `sclk_in` edge, and is 1 at all other times.
- R11: After the eighth rising edge, `irq` is high for exactly one cycle, and the unit then ignores further clock edges until it is started again.
- R12: Reads return the control register when `rd_addr`=0 and the shift/data register when `rd_addr`=1.
- R13: After reset the control register is 0, `sout`=1, `sclk_out`=1, `rdy_n`=1, `irq`=0 and `err_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 data |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read select: 0 control, 1 data |
| rd_data | output | 8 | Read data |
| sin | input | 1 | Serial data in |
| sclk_in | input | 1 | External shift clock |
| sout | output | 1 | Serial data out |
| sclk_out | output | 1 | Internal shift clock out |
| sclk_oe | output | 1 | Clock pin driven by the unit |
| rdy_n | output | 1 | Ready to external master, active low |
| rdy_oe | output | 1 | Ready pin function enable |
| pin_sel | output | 1 | Serial pin function enable |
| od_en | output | 1 | Open-drain output type |
| irq | output | 1 | Transfer-complete pulse |
| err_flag | output | 1 | Arm refused because the external clock was low |

## Verification
The assertions check the following on every cycle. `sout` holds steady outside falling events. The bit counter advances by one on each rising event. A stopped prescaler keeps the clock high. A refused external write leaves the unit unarmed with the error set. `irq` never lasts two cycles. Ready is never low unless the unit is armed, and an idle unit's data register never moves. Only the bench scenarios can show the end-to-end results: the exact period for each divider code, the received byte order, the serial bit order on `sout`, and that no stray external edges corrupt data.

// File: rtl/csio_pkg.sv
package csio_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int PC_W   = 8;

    typedef struct packed {
        logic       rdy_en;
        logic       int_clk;
        logic       msb_first;
        logic       od_en;
        logic       pin_sel;
        logic [2:0] div_sel;
    } ctrl_t;

    // Half period of the internal shift clock in system clocks; 0 marks a reserved code.
    function automatic logic [PC_W-1:0] half_of(input logic [2:0] sel);
        case (sel)
            3'd0:    half_of = PC_W'(4);
            3'd1:    half_of = PC_W'(8);
            3'd2:    half_of = PC_W'(16);
            3'd3:    half_of = PC_W'(32);
            3'd6:    half_of = PC_W'(64);
            3'd7:    half_of = PC_W'(128);
            default: half_of = '0;
        endcase
    endfunction

    function automatic logic is_reserved(input logic [2:0] sel);
        is_reserved = (half_of(sel) == '0);
    endfunction
endpackage

// File: rtl/csio_prescaler.sv
module csio_prescaler
    import csio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       clr,
    input  logic [2:0] sel,
    output logic       fall_ev,
    output logic       rise_ev,
    output logic       sclk_o
);
    logic [PC_W-1:0] pc_q;
    logic            ph_q;
    logic [PC_W-1:0] half_m1;
    logic            term;

    assign half_m1 = half_of(sel) - PC_W'(1);
    assign term    = run && (pc_q == half_m1);
    assign fall_ev = term && ph_q;
    assign rise_ev = term && !ph_q;
    assign sclk_o  = ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            ph_q <= 1'b1;
        end else if (clr || !run) begin
            pc_q <= '0;
            ph_q <= 1'b1;
        end else if (term) begin
            pc_q <= '0;
            ph_q <= !ph_q;
        end else begin
            pc_q <= pc_q + PC_W'(1);
        end
    end

    // R2/R5: a stopped prescaler holds the clock high with no events
    a_r2_stopped_idle_high: assert property (@(posedge clk) disable iff (rst)
        !run |=> (sclk_o && !fall_ev));
endmodule

// File: rtl/csio_clk_sync.sv
module csio_clk_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic fall,
    output logic rise
);
    logic ff1_q, ff2_q, prv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ff1_q <= 1'b1;
            ff2_q <= 1'b1;
            prv_q <= 1'b1;
        end else begin
            ff1_q <= pin;
            ff2_q <= ff1_q;
            prv_q <= ff2_q;
        end
    end

    assign level = ff2_q;
    assign fall  = prv_q && !ff2_q;
    assign rise  = !prv_q && ff2_q;
endmodule

// File: rtl/csio_shifter.sv
module csio_shifter
    import csio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              msb_first,
    input  logic              fall,
    input  logic              rise,
    input  logic              sin,
    output logic [DATA_W-1:0] sr_o,
    output logic              sout_o,
    output logic              done_o
);
    logic [DATA_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sout_q;
    logic              out_bit;
    logic [DATA_W-1:0] shifted;

    assign out_bit = msb_first ? sr_q[DATA_W-1] : sr_q[0];
    assign shifted = msb_first ? {sr_q[DATA_W-2:0], sin} : {sin, sr_q[DATA_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            sout_q <= 1'b1;
        end else begin
            if (fall) sout_q <= out_bit;
            if (load) begin
                sr_q  <= load_data;
                cnt_q <= '0;
            end else if (rise) begin
                sr_q  <= shifted;
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign sr_o   = sr_q;
    assign sout_o = sout_q;
    assign done_o = rise && (cnt_q == CNT_W'(DATA_W - 1));

    // R5: serial output moves only on a falling event
    a_r5_sout_on_fall_only: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(sout_q));
    // R11: each rising event advances the bit count by one
    a_r11_count_step: assert property (@(posedge clk) disable iff (rst)
        (rise && !load) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));
endmodule

// File: rtl/csio_unit.sv
module csio_unit
    import csio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_addr,
    output logic [7:0] rd_data,
    input  logic       sin,
    input  logic       sclk_in,
    output logic       sout,
    output logic       sclk_out,
    output logic       sclk_oe,
    output logic       rdy_n,
    output logic       rdy_oe,
    output logic       pin_sel,
    output logic       od_en,
    output logic       irq,
    output logic       err_flag
);
    ctrl_t             ctrl_q;
    logic              active_q, wait_q, err_q, irq_q;
    logic              data_wr, ctrl_wr, reserved, run;
    logic              p_fall, p_rise;
    logic              x_lvl, x_fall, x_rise;
    logic              sh_fall, sh_rise, done;
    logic              ext_edge;
    logic [DATA_W-1:0] sr;

    assign data_wr  = wr_en && wr_addr;
    assign ctrl_wr  = wr_en && !wr_addr;
    assign reserved = is_reserved(ctrl_q.div_sel);
    assign run      = active_q && ctrl_q.int_clk && !reserved;

    csio_prescaler u_presc (
        .clk(clk), .rst(rst), .run(run), .clr(data_wr), .sel(ctrl_q.div_sel),
        .fall_ev(p_fall), .rise_ev(p_rise), .sclk_o(sclk_out)
    );

    csio_clk_sync u_sync (
        .clk(clk), .rst(rst), .pin(sclk_in),
        .level(x_lvl), .fall(x_fall), .rise(x_rise)
    );

    assign ext_edge = !ctrl_q.int_clk && active_q && (x_fall || x_rise);
    assign sh_fall  = ctrl_q.int_clk ? p_fall : (active_q && x_fall);
    assign sh_rise  = ctrl_q.int_clk ? p_rise : (active_q && x_rise);

    csio_shifter u_shift (
        .clk(clk), .rst(rst), .load(data_wr), .load_data(wr_data),
        .msb_first(ctrl_q.msb_first), .fall(sh_fall), .rise(sh_rise), .sin(sin),
        .sr_o(sr), .sout_o(sout), .done_o(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            active_q <= 1'b0;
            wait_q   <= 1'b0;
            err_q    <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= done;
            if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data);
            if (data_wr) begin
                if (ctrl_q.int_clk) begin
                    active_q <= !reserved;
                    wait_q   <= 1'b0;
                end else begin
                    active_q <= x_lvl;
                    wait_q   <= x_lvl;
                    err_q    <= !x_lvl;
                end
            end else begin
                if (done)     active_q <= 1'b0;
                if (ext_edge) wait_q   <= 1'b0;
            end
        end
    end

    assign rd_data  = rd_addr ? sr : ctrl_q;
    assign sclk_oe  = ctrl_q.pin_sel && ctrl_q.int_clk;
    assign rdy_n    = !wait_q;
    assign rdy_oe   = ctrl_q.rdy_en;
    assign pin_sel  = ctrl_q.pin_sel;
    assign od_en    = ctrl_q.od_en;
    assign irq      = irq_q;
    assign err_flag = err_q;

    // R9: a refused external write leaves the unit unarmed with the error set
    a_r9_refused_arm: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !ctrl_q.int_clk && !x_lvl) |=> (!active_q && err_flag && rdy_n));
    // R11: the completion request is a single-cycle pulse
    a_r11_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    // R10: ready is only asserted while armed
    a_r10_ready_needs_arm: assert property (@(posedge clk) disable iff (rst)
        !rdy_n |-> active_q);
    // R8: an idle unit's data register does not move
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !data_wr) |=> $stable(sr));
endmodule

// File: tb/csio_unit_tb.sv
module csio_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sin, sclk_in = 1'b1;
    logic       sout, sclk_out, sclk_oe, rdy_n, rdy_oe, pin_sel, od_en, irq, err_flag;
    logic       drive_int = 1'b1, sin_int = 1'b0, sin_ext = 1'b0;

    int checks = 0, errors = 0, cyc = 0;
    bit cmp_en = 0;

    assign sin = drive_int ? sin_int : sin_ext;

    always #5 clk = !clk;

    csio_unit dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sin(sin), .sclk_in(sclk_in),
        .sout(sout), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .rdy_n(rdy_n),
        .rdy_oe(rdy_oe), .pin_sel(pin_sel), .od_en(od_en), .irq(irq), .err_flag(err_flag)
    );

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic int mdiv(input int c);
        case (c)
            0: return 8;   1: return 16;  2: return 32;
            3: return 64;  6: return 128; 7: return 256;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
    endfunction

    // Behavioural reference model, advanced on each rising clock edge
    int m_ctrl, m_sr, m_cnt, m_act, m_wait, m_err, m_irq, m_sout, m_pc, m_ph, s1, s2, s3;
    always @(posedge clk) begin : model
        int dv, hf, im, ms, evf, evr, dn, dwr, cwr, rn, na, nw;
        if (rst) begin
            m_ctrl = 0; m_sr = 0; m_cnt = 0; m_act = 0; m_wait = 0; m_err = 0;
            m_irq = 0; m_sout = 1; m_pc = 0; m_ph = 1; s1 = 1; s2 = 1; s3 = 1;
        end else begin
            dv = mdiv(m_ctrl & 7); hf = dv / 2;
            im = (m_ctrl >> 6) & 1; ms = (m_ctrl >> 5) & 1;
            dwr = int'(wr_en && wr_addr); cwr = int'(wr_en && !wr_addr);
            rn = int'(m_act != 0 && im != 0 && dv != 0);
            if (im != 0) begin
                evf = int'(rn != 0 && m_pc == hf - 1 && m_ph == 1);
                evr = int'(rn != 0 && m_pc == hf - 1 && m_ph == 0);
            end else begin
                evf = int'(m_act != 0 && s3 == 1 && s2 == 0);
                evr = int'(m_act != 0 && s3 == 0 && s2 == 1);
            end
            dn = int'(evr != 0 && m_cnt == 7);
            if (evf != 0) m_sout = (ms != 0) ? ((m_sr >> 7) & 1) : (m_sr & 1);
            if (dwr != 0) begin
                m_sr = wr_data; m_cnt = 0;
            end else if (evr != 0) begin
                if (ms != 0) m_sr = ((m_sr << 1) | int'(sin)) & 255;
                else         m_sr = (m_sr >> 1) | (int'(sin) << 7);
                m_cnt = m_cnt + 1;
            end
            if (dwr != 0 || rn == 0) begin m_pc = 0; m_ph = 1; end
            else if (m_pc == hf - 1) begin m_pc = 0; m_ph = 1 - m_ph; end
            else m_pc = m_pc + 1;
            if (dwr != 0) begin
                if (im != 0) begin na = int'(dv != 0); nw = 0; end
                else begin na = s2; nw = s2; m_err = 1 - s2; end
            end else begin
                na = (dn != 0) ? 0 : m_act;
                nw = (im == 0 && (evf != 0 || evr != 0)) ? 0 : m_wait;
            end
            m_act = na; m_wait = nw; m_irq = dn;
            if (cwr != 0) m_ctrl = wr_data;
            s3 = s2; s2 = s1; s1 = int'(sclk_in);
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R5 sout", int'(sout), m_sout);
            chk("R1 sclk_out", int'(sclk_out), m_ph);
            chk("R11 irq", int'(irq), m_irq);
            chk("R10 rdy_n", int'(rdy_n), 1 - m_wait);
            chk("R9 err_flag", int'(err_flag), m_err);
            chk("R12 rd_data", int'(rd_data), rd_addr ? m_sr : m_ctrl);
            chk("R3 pin_sel", int'(pin_sel), (m_ctrl >> 3) & 1);
            chk("R3 sclk_oe", int'(sclk_oe), ((m_ctrl >> 3) & (m_ctrl >> 6)) & 1);
        end
    end

    // Bench-side serial partner for internal mode and tx capture
    logic [7:0] pat_q = 8'h00;
    int  bi = 0, tx_n = 0, irq_cnt = 0;
    logic prev_sclk = 1'b1;
    logic [7:0] tx_cap = 8'h00;
    always @(posedge clk) begin
        irq_cnt <= irq_cnt + int'(irq);
        prev_sclk <= sclk_out;
        if (wr_en && wr_addr) begin
            bi <= 0; tx_n <= 0;
        end else begin
            if (prev_sclk && !sclk_out) begin
                sin_int <= pat_q[bi[2:0]];
                bi <= bi + 1;
            end
            if (!prev_sclk && sclk_out && tx_n < 8) begin
                tx_cap[tx_n[2:0]] <= sout;
                tx_n <= tx_n + 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_int(input logic [7:0] c, input logic [7:0] d, input logic [7:0] p, input bit restart);
        int n, div;
        logic [7:0] txb;
        div = mdiv(int'(c[2:0]));
        drive_int = 1'b1; pat_q = p; rd_addr = 1'b1;
        wr(1'b0, c);
        if (restart) begin
            wr(1'b1, 8'hFF);
            repeat (10) @(negedge clk);
        end
        wr(1'b1, d);
        n = 0;
        while (!irq && n < 5000) begin @(negedge clk); n++; end
        chk("R1/R6 cycles to irq", n, 8 * div);
        chk("R4 received byte", int'(rd_data), c[5] ? int'(rev8(p)) : int'(p));
        @(negedge clk);
        txb = c[5] ? rev8(tx_cap) : tx_cap;
        chk("R5 transmitted bits", int'(txb), int'(d));
        chk("R11 irq single pulse", int'(irq), 0);
    endtask

    task automatic ext_pulses(input logic [7:0] p, input int cnt, input bit check_rdy);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk); sclk_in = 1'b0; sin_ext = p[i];
            repeat (6) @(negedge clk);
            if (check_rdy && i == 0) chk("R10 ready released on first edge", int'(rdy_n), 1);
            sclk_in = 1'b1;
            repeat (6) @(negedge clk);
        end
    endtask

    initial begin
        int ic;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cmp_en = 1;
        @(negedge clk);
        // R13 reset state
        chk("R13 sout", int'(sout), 1);
        chk("R13 sclk_out", int'(sclk_out), 1);
        chk("R13 rdy_n", int'(rdy_n), 1);
        chk("R13 irq", int'(irq), 0);
        chk("R13 err_flag", int'(err_flag), 0);
        chk("R13 ctrl", int'(rd_data), 0);

        // R3 / R12 pin enables and readback
        wr(1'b0, 8'hD8);
        chk("R3 pin_sel", int'(pin_sel), 1);
        chk("R3 od_en", int'(od_en), 1);
        chk("R3 rdy_oe", int'(rdy_oe), 1);
        chk("R3 sclk_oe", int'(sclk_oe), 1);
        chk("R12 ctrl readback", int'(rd_data), 8'hD8);

        // R6 / R1 / R4 / R5 internal transfers, every valid code, both orders
        do_int(8'h48, 8'hA5, 8'h3C, 1'b0);
        do_int(8'h69, 8'h5A, 8'h96, 1'b0);
        do_int(8'h4A, 8'h81, 8'hE1, 1'b0);
        do_int(8'h6B, 8'h0F, 8'h42, 1'b0);
        do_int(8'h4E, 8'hC6, 8'h7D, 1'b0);
        do_int(8'h6F, 8'h33, 8'hB8, 1'b0);
        do_int(8'h48, 8'h6E, 8'h1F, 1'b1);

        // R2 reserved codes
        for (int k = 4; k < 6; k++) begin
            ic = irq_cnt;
            wr(1'b0, 8'h48 | 8'(k));
            wr(1'b1, 8'h99);
            repeat (300) @(negedge clk);
            chk("R2 clock stays high", int'(sclk_out), 1);
            chk("R2 no irq", irq_cnt, ic);
            chk("R2 data loaded", int'(rd_data), 8'h99);
        end

        // R7 / R10 external-clock transfer
        drive_int = 1'b0;
        wr(1'b0, 8'h88);
        chk("R3 sclk_oe ext", int'(sclk_oe), 0);
        ic = irq_cnt;
        wr(1'b1, 8'hC3);
        chk("R10 ready after arm", int'(rdy_n), 0);
        chk("R9 no error on arm", int'(err_flag), 0);
        ext_pulses(8'h5B, 8, 1'b1);
        repeat (4) @(negedge clk);
        chk("R7 received byte", int'(rd_data), 8'h5B);
        chk("R11 one irq", irq_cnt, ic + 1);

        // R8 edges ignored when not armed
        ext_pulses(8'hFF, 4, 1'b0);
        repeat (4) @(negedge clk);
        chk("R8 data unchanged", int'(rd_data), 8'h5B);
        chk("R8 no irq", irq_cnt, ic + 1);

        // R9 write while external clock low
        sclk_in = 1'b0;
        repeat (4) @(negedge clk);
        wr(1'b1, 8'h77);
        chk("R9 error set", int'(err_flag), 1);
        chk("R9 not armed", int'(rdy_n), 1);
        sclk_in = 1'b1;
        repeat (6) @(negedge clk);
        ext_pulses(8'h00, 8, 1'b0);
        repeat (4) @(negedge clk);
        chk("R9 data not shifted", int'(rd_data), 8'h77);
        chk("R9 no irq", irq_cnt, ic + 1);
        wr(1'b1, 8'h11);
        chk("R9 error cleared", int'(err_flag), 0);
        chk("R10 armed again", int'(rdy_n), 0);
        ext_pulses(8'hA6, 8, 1'b1);
        repeat (4) @(negedge clk);
        chk("R7 second byte", int'(rd_data), 8'hA6);

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule